// File: doc/BRIEF.md
# Reversing Star-Delta Motor Starter

This block controls a reversible three-phase induction motor that is started in star and then switched over to delta. Three plain control inputs arrive already synchronised and debounced: a stop command and one start request per direction. Four registered outputs drive the direction contactors (left, right) and the winding contactors (star, delta).

A start request sets a self-holding direction latch. The two latches lock each other out, and stop clears both. Whenever either latch is held the motor is running. The start of a run closes the star contactor for a parameterised number of clock cycles. A short dead gap follows in which star and delta are both open, so the two winding contactors never overlap. Delta then closes and stays closed until the run ends. Both timings are parameters counted in clock cycles, `STAR_CYC` and `GAP_CYC`, each at least 1.

Top module: `sdr_starter_top`

## Requirements
- R1: A left request (`left_req_i`=1, with `stop_i`=0 and `right_o`=0) sets `left_o` at the next rising edge. `left_o` then stays 1 after the request is released, until stop is seen.
- R2: The right latch behaves like the left latch with the roles swapped. A request for the other direction while one latch is held is ignored, and `left_o` and `right_o` are never 1 together.
- R3: If both direction requests are 1 in the same cycle while neither latch is held, neither latch sets.
- R4: `stop_i`=1 clears both direction outputs at the next edge and overrides any request made in the same cycle.
- R5: `star_o` rises on the same edge as the direction output that starts a run and stays 1 for exactly `STAR_CYC` cycles.
- R6: Directly after the star phase, `star_o` and `delta_o` are both 0 for exactly `GAP_CYC` cycles. The two are never 1 in the same cycle.
- R7: After the gap, `delta_o` is 1 and stays 1 for as long as a direction output stays 1.
- R8: When the run ends, `star_o` and `delta_o` fall on the same edge as the direction output.
- R9: A start after a stop runs the whole sequence again from the beginning: star, then gap, then delta.
- R10: While `rst_n`=0, and directly after reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Stop command, level sensitive |
| left_req_i | input | 1 | Start request, left direction |
| right_req_i | input | 1 | Start request, right direction |
| left_o | output | 1 | Left direction contactor |
| right_o | output | 1 | Right direction contactor |
| star_o | output | 1 | Star winding contactor |
| delta_o | output | 1 | Delta winding contactor |

## Verification
A corrupted direction latch shows up at the direction outputs on the very next edge. It appears as a lost hold, a missed interlock or a stop that is not obeyed. Because the winding timing follows the latches, the same fault also shifts the star and delta outputs in that cycle. A wrong phase counter appears within one star or gap window as a star pulse of the wrong length, a gap that is too short, or overlapping winding contactors. These faults show at the ports within `STAR_CYC + GAP_CYC` cycles of the start of a run.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STAR  = 2'd1,
    PH_GAP   = 2'd2,
    PH_DELTA = 2'd3
  } sdr_phase_e;
endpackage

// File: rtl/sdr_dir_interlock.sv
module sdr_dir_interlock (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic left_req_i,
  input  logic right_req_i,
  output logic left_q,
  output logic right_q,
  output logic run_nxt
);
  logic left_d, right_d;

  // a tie between requests (only possible while idle) sets nothing
  always_comb begin
    left_d  = !stop_i && !right_q && (left_q  || (left_req_i  && !right_req_i));
    right_d = !stop_i && !left_q  && (right_q || (right_req_i && !left_req_i));
    run_nxt = left_d || right_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= 1'b0;
      right_q <= 1'b0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_q && right_q));
  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!left_q && !right_q));
  a_r1_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q && !stop_i) |=> left_q);
  a_r3_tie_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_q && !right_q && left_req_i && right_req_i) |=> (!left_q && !right_q));
endmodule

// File: rtl/sdr_tick_timer.sv
module sdr_tick_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] lim_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == lim_i);
endmodule

// File: rtl/sdr_phase_seq.sv
module sdr_phase_seq
  import sdr_pkg::*;
#(
  parameter int STAR_CYC = 5,
  parameter int GAP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_nxt_i,
  output logic star_o,
  output logic delta_o
);
  localparam int MAXC = (STAR_CYC > GAP_CYC) ? STAR_CYC : GAP_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] STAR_LIM = CW'(STAR_CYC - 1);
  localparam logic [CW-1:0] GAP_LIM  = CW'(GAP_CYC - 1);

  sdr_phase_e    ph_q, ph_d;
  logic          clr, last;
  logic [CW-1:0] lim;

  always_comb begin
    ph_d = ph_q;
    if (!run_nxt_i) ph_d = PH_IDLE;
    else begin
      case (ph_q)
        PH_IDLE:  ph_d = PH_STAR;
        PH_STAR:  if (last) ph_d = PH_GAP;
        PH_GAP:   if (last) ph_d = PH_DELTA;
        default:  ph_d = PH_DELTA;
      endcase
    end
    lim = (ph_q == PH_STAR) ? STAR_LIM : GAP_LIM;
    clr = (ph_d != ph_q) || (ph_q == PH_IDLE) || (ph_q == PH_DELTA);
  end

  sdr_tick_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .lim_i  (lim),
    .last_o (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign star_o  = (ph_q == PH_STAR);
  assign delta_o = (ph_q == PH_DELTA);

  a_r5_star_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && run_nxt_i) |=> star_o);
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(star_o && delta_o));
  a_r6_gap_after_star: assert property (@(posedge clk) disable iff (!rst_n)
    (star_o && run_nxt_i && !$stable(last) && last) |=> !delta_o);
  a_r7_delta_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_o && run_nxt_i) |=> delta_o);
  a_r8_drop_together: assert property (@(posedge clk) disable iff (!rst_n)
    !run_nxt_i |=> (!star_o && !delta_o));
endmodule

// File: rtl/sdr_starter_top.sv
module sdr_starter_top #(
  parameter int STAR_CYC = 5,
  parameter int GAP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic left_req_i,
  input  logic right_req_i,
  output logic left_o,
  output logic right_o,
  output logic star_o,
  output logic delta_o
);
  logic run_nxt;

  sdr_dir_interlock u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .left_req_i  (left_req_i),
    .right_req_i (right_req_i),
    .left_q      (left_o),
    .right_q     (right_o),
    .run_nxt     (run_nxt)
  );

  sdr_phase_seq #(.STAR_CYC(STAR_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_nxt_i (run_nxt),
    .star_o    (star_o),
    .delta_o   (delta_o)
  );

  a_r5_winding_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (star_o || delta_o) |-> (left_o || right_o));
  a_r9_restart_in_star: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_o && !right_o) |=> ((left_o || right_o) ? (star_o && !delta_o) : 1'b1));
endmodule

// File: tb/sdr_starter_top_bench.sv
module sdr_starter_top_bench;
  localparam int S = 5;
  localparam int G = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop = 1'b0, pl = 1'b0, pr = 1'b0;
  logic left_o, right_o, star_o, delta_o;
  int checks = 0, failures = 0;
  bit done = 0;

  logic mkl = 0, mkr = 0, mrun = 0;
  int mt = 0;

  always #4 clk = ~clk;

  sdr_starter_top #(.STAR_CYC(S), .GAP_CYC(G)) u_sdr_starter_top (
    .clk(clk), .rst_n(rst_n), .stop_i(stop), .left_req_i(pl), .right_req_i(pr),
    .left_o(left_o), .right_o(right_o), .star_o(star_o), .delta_o(delta_o));

  function automatic logic exp_star();
    return mrun && (mt < S);
  endfunction
  function automatic logic exp_delta();
    return mrun && (mt >= S + G);
  endfunction
  function automatic logic in_gap();
    return mrun && (mt >= S) && (mt < S + G);
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic l, input logic r);
    logic nkl, nkr, nrun;
    stop = s; pl = l; pr = r;
    @(posedge clk);
    nkl  = !s && !mkr && (mkl || (l && !r));
    nkr  = !s && !mkl && (mkr || (r && !l));
    nrun = nkl || nkr;
    if (nrun) mt = mrun ? ((mt < 100000) ? mt + 1 : mt) : 0;
    mkl = nkl; mkr = nkr; mrun = nrun;
    @(negedge clk);
    check("R1", "left_o", left_o, mkl);
    check("R2", "right_o", right_o, mkr);
    check(in_gap() ? "R6" : "R5", "star_o", star_o, exp_star());
    check(in_gap() ? "R6" : "R7", "delta_o", delta_o, exp_delta());
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R10", "left_o in reset", left_o, 1'b0);
    check("R10", "star_o in reset", star_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "right_o after reset", right_o, 1'b0);
    check("R10", "delta_o after reset", delta_o, 1'b0);

    // R1/R5: start left, star together with direction
    step(0, 1, 0);
    check("R1", "left set", left_o, 1'b1);
    check("R5", "star with left", star_o, 1'b1);
    for (int i = 0; i < S - 1; i++) step(0, 0, 0);
    check("R5", "star last cycle", star_o, 1'b1);
    step(0, 0, 0);
    check("R6", "gap star", star_o, 1'b0);
    check("R6", "gap delta", delta_o, 1'b0);
    for (int i = 0; i < G - 1; i++) step(0, 0, 0);
    check("R6", "gap end delta", delta_o, 1'b0);
    step(0, 0, 0);
    check("R7", "delta closed", delta_o, 1'b1);
    // R2: opposite request ignored while left held
    step(0, 0, 1);
    check("R2", "right blocked", right_o, 1'b0);
    check("R7", "delta held", delta_o, 1'b1);
    // R4/R8: stop drops everything together
    step(1, 0, 0);
    check("R4", "left cleared", left_o, 1'b0);
    check("R8", "delta dropped", delta_o, 1'b0);
    // R3: tie while idle
    step(0, 1, 1);
    check("R3", "tie left", left_o, 1'b0);
    check("R3", "tie right", right_o, 1'b0);
    // right run, stop mid-star
    step(0, 0, 1);
    check("R2", "right set", right_o, 1'b1);
    step(0, 0, 0);
    step(1, 0, 1);
    check("R8", "star dropped", star_o, 1'b0);
    // R4: stop overrides request
    step(1, 1, 0);
    check("R4", "stop beats request", left_o, 1'b0);
    // R9: restart runs whole sequence
    step(0, 1, 0);
    check("R9", "restart star", star_o, 1'b1);
    check("R9", "restart no delta", delta_o, 1'b0);
    for (int i = 0; i < S + G; i++) step(0, 0, 0);
    check("R9", "restart delta", delta_o, 1'b1);
    step(1, 0, 0);

    // constrained random with fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic s, l, r;
      s = ($urandom % 24) == 0;
      l = ($urandom % 10) == 0;
      r = ($urandom % 10) == 0;
      step(s, l, r);
      check("R2", "exclusive dirs", left_o && right_o, 1'b0);
      check("R6", "exclusive windings", star_o && delta_o, 1'b0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule